// File: doc/BRIEF.md
# Acknowledgement Wait Tracker

This block sits on the sending side of a link that carries one request at a time and expects an acknowledgement for each. A requester offers a message of one of three types on a valid/ready input. The block forwards the accepted message as a one-cycle send pulse tagged with its type. It then closes its input until the message is resolved, either by an acknowledgement from the peer or by the expiry of a wait timer.

The wait limit is given in milliseconds on a configuration input and turned into clock ticks with a ticks-per-millisecond parameter. The limit is latched when the message is accepted. Each outcome is reported by a one-cycle pulse: acknowledged, timed out, or late acknowledgement. Cycle-exact rules settle an acknowledgement that arrives close to the expiry. The message type never affects the timer.

Back-pressure rules: `req_ready` is high only while nothing is outstanding. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. A requester may hold `req_valid` high for as long as it likes, and the request is taken at the first edge on which the block is ready.

Top module: `ack_wait_tracker`

## Requirements
- R1: A request taken at edge k produces `send_pulse` high for exactly the cycle after edge k. During that cycle `send_kind` carries the accepted type code, where 0, 1 and 2 are the first, second and third message types.
- R2: From the edge that takes a request until the edge that produces its done or timeout pulse, `req_ready` is low. Only one message is outstanding at any time.
- R3: The wait length L in cycles is `limit_ms * TICKS_PER_MS` for `limit_ms` from 1 to 3. A value of 0 is treated as 1.
- R4: Call the cycle in which `send_pulse` is high cycle 1. If no acknowledgement arrives, `timeout_pulse` is high in cycle L+1 and `req_ready` is high again in that same cycle.
- R5: An `ack_in` in any cycle c from 1 to L-1 produces `done_pulse` in cycle c+1 and no timeout. This includes c = L-1, one cycle before expiry.
- R6: An `ack_in` in cycle L, which is the expiry cycle, produces one `done_pulse` in cycle L+1 and no `timeout_pulse`.
- R7: An `ack_in` in cycle L+1, the cycle in which `timeout_pulse` is high, is not treated as a completion. It produces `late_ack_pulse` in cycle L+2.
- R8: An `ack_in` while idle, when it does not fall in the late window, produces no pulse.
- R9: `limit_ms` is sampled only at the edge that takes a request. Changing it while a message is outstanding does not alter that message's wait.
- R10: After a timeout, the next message gets a full wait of its own L, so timeouts repeat correctly.
- R11: Asserting `rst_n` low while a message is outstanding returns the block to idle. `req_ready` is high, no pulse is produced, and the next message waits its full L.
- R12: At most one of `done_pulse`, `timeout_pulse` and `late_ack_pulse` is high in any cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request (idle) |
| req_kind | input | KIND_W | Message type code of the offered request |
| limit_ms | input | MS_W | Wait limit in milliseconds, 0 read as 1 |
| ack_in | input | 1 | Acknowledgement from the peer |
| send_pulse | output | 1 | One-cycle send strobe toward the peer |
| send_kind | output | KIND_W | Type code of the message being sent |
| done_pulse | output | 1 | Message acknowledged |
| timeout_pulse | output | 1 | Wait limit expired without acknowledgement |
| late_ack_pulse | output | 1 | Acknowledgement arrived one cycle after the timeout |

## Verification
On every cycle, the assertions check the following: the input is closed while a send is in flight, the counter never reaches its latched limit, the outcome pulses are mutually exclusive, the block is idle when a timeout is reported, and a late pulse only follows a timeout. Some behaviour can only be shown by the bench's scenarios: the exact cycle of each outcome for acknowledgements placed one cycle before, on, and one cycle after the expiry; the limit being held against mid-wait reprogramming; repeated timeouts; and a clean restart after a reset in mid-wait.

// File: rtl/ackw_pkg.sv
package ackw_pkg;
  typedef enum logic [1:0] {
    KIND_FIRST  = 2'd0,
    KIND_SECOND = 2'd1,
    KIND_THIRD  = 2'd2
  } msg_kind_e;

  function automatic int unsigned cnt_width(input int unsigned ticks, input int unsigned ms_w);
    return $clog2(((1 << ms_w) - 1) * ticks + 1);
  endfunction
endpackage

// File: rtl/ackw_limit_calc.sv
module ackw_limit_calc #(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned MS_W         = 2,
  parameter int unsigned CNT_W        = 12
) (
  input  logic [MS_W-1:0]  ms_in,
  output logic [CNT_W-1:0] ticks_out
);
  logic [MS_W-1:0] ms_eff;

  // zero is read as the smallest legal limit
  always_comb begin
    ms_eff    = (ms_in == '0) ? MS_W'(1) : ms_in;
    ticks_out = CNT_W'(ms_eff) * CNT_W'(TICKS_PER_MS);
  end
endmodule

// File: rtl/ackw_wait_counter.sv
module ackw_wait_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] limit_in,
  input  logic             stop,
  output logic             running,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  assign expire = running && (cnt_q == lim_q - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else if (load) begin
      running <= 1'b1;
      cnt_q   <= '0;
      lim_q   <= limit_in;
    end else if (running) begin
      if (stop || expire) begin
        running <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R4: the count stays below the limit latched for this message
  p_cnt_below_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < lim_q));

  // R10: each load restarts a fresh wait from zero
  p_load_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (running && cnt_q == '0));

  // R9: the latched limit holds while a message waits
  p_limit_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$past(load)) |-> $stable(lim_q));
endmodule

// File: rtl/ackw_outcome.sv
module ackw_outcome (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic expire,
  input  logic ack_in,
  output logic done_pulse,
  output logic timeout_pulse,
  output logic late_ack_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse     <= 1'b0;
      timeout_pulse  <= 1'b0;
      late_ack_pulse <= 1'b0;
    end else begin
      // an ack on the expiry cycle wins over the timeout
      done_pulse     <= running && ack_in;
      timeout_pulse  <= expire && !ack_in;
      late_ack_pulse <= timeout_pulse && ack_in;
    end
  end

  // R12: outcome pulses never overlap
  p_pulses_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, timeout_pulse, late_ack_pulse}));

  // R7: a late pulse only follows a timeout
  p_late_after_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(late_ack_pulse) |-> $past(timeout_pulse));

  // R12: a timeout pulse lasts one cycle
  p_timeout_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);
endmodule

// File: rtl/ack_wait_tracker.sv
module ack_wait_tracker #(
  parameter int unsigned TICKS_PER_MS = 1000,
  parameter int unsigned MS_W         = 2,
  parameter int unsigned KIND_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [MS_W-1:0]   limit_ms,
  input  logic              ack_in,
  output logic              send_pulse,
  output logic [KIND_W-1:0] send_kind,
  output logic              done_pulse,
  output logic              timeout_pulse,
  output logic              late_ack_pulse
);
  import ackw_pkg::*;

  localparam int unsigned CNT_W = cnt_width(TICKS_PER_MS, MS_W);

  logic [CNT_W-1:0] limit_ticks;
  logic             running;
  logic             expire;
  logic             accept;

  assign req_ready = !running;
  assign accept    = req_valid && req_ready;

  ackw_limit_calc #(
    .TICKS_PER_MS(TICKS_PER_MS),
    .MS_W(MS_W),
    .CNT_W(CNT_W)
  ) u_limit (
    .ms_in(limit_ms),
    .ticks_out(limit_ticks)
  );

  ackw_wait_counter #(
    .CNT_W(CNT_W)
  ) u_counter (
    .clk(clk),
    .rst_n(rst_n),
    .load(accept),
    .limit_in(limit_ticks),
    .stop(ack_in),
    .running(running),
    .expire(expire)
  );

  ackw_outcome u_outcome (
    .clk(clk),
    .rst_n(rst_n),
    .running(running),
    .expire(expire),
    .ack_in(ack_in),
    .done_pulse(done_pulse),
    .timeout_pulse(timeout_pulse),
    .late_ack_pulse(late_ack_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_pulse <= 1'b0;
      send_kind  <= '0;
    end else begin
      send_pulse <= accept;
      if (accept) send_kind <= req_kind;
    end
  end

  // R2: the input stays closed while a send is in flight
  p_busy_on_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
    send_pulse |-> !req_ready);

  // R4: a timeout reports an idle block
  p_idle_on_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> req_ready);

  // R1: a send strobe lasts one cycle, since the next take needs an idle block
  p_send_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    send_pulse |=> !send_pulse);
endmodule

// File: tb/ack_wait_tracker_bench.sv
module ack_wait_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPM        = 4;

  typedef struct {
    int         cyc;
    logic [3:0] code;
    logic [1:0] kind;
  } ev_t;

  localparam logic [3:0] EV_SEND = 4'b1000;
  localparam logic [3:0] EV_DONE = 4'b0100;
  localparam logic [3:0] EV_TO   = 4'b0010;
  localparam logic [3:0] EV_LATE = 4'b0001;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [1:0] limit_ms = 2'd1;
  logic       ack_in = 1'b0;
  logic       send_pulse;
  logic [1:0] send_kind;
  logic       done_pulse;
  logic       timeout_pulse;
  logic       late_ack_pulse;

  int  cyc = 0;
  int  n_run = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;
  ev_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ack_wait_tracker #(.TICKS_PER_MS(TPM), .MS_W(2), .KIND_W(2)) u_ack_wait_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .limit_ms(limit_ms), .ack_in(ack_in),
    .send_pulse(send_pulse), .send_kind(send_kind), .done_pulse(done_pulse),
    .timeout_pulse(timeout_pulse), .late_ack_pulse(late_ack_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int wait_len(input int ms);
    return ((ms == 0) ? 1 : ms) * TPM;
  endfunction

  // monitor: compare the pulses against the scoreboard each cycle
  always @(negedge clk) begin
    logic [3:0] obs;
    logic [3:0] exp;
    logic [1:0] kexp;
    if (rst_n) begin
      obs  = {send_pulse, done_pulse, timeout_pulse, late_ack_pulse};
      exp  = '0;
      kexp = '0;
      while (expq.size() > 0 && expq[0].cyc <= cyc) begin
        if (expq[0].cyc < cyc) check(1'b0, "R4 missed event", 0, int'(expq[0].code));
        else begin
          exp = exp | expq[0].code;
          if (expq[0].code == EV_SEND) kexp = expq[0].kind;
        end
        void'(expq.pop_front());
      end
      if (obs != '0 || exp != '0)
        check(obs == exp, "R12 pulse pattern (R1 R4 R5 R6 R7)", int'(obs), int'(exp));
      if (exp[3] && obs[3])
        check(send_kind == kexp, "R1 send kind", int'(send_kind), int'(kexp));
    end
  end

  // ack_off: cycle offset of ack from the request cycle, negative for none
  task automatic do_req(input logic [1:0] kind, input logic [1:0] ms, input int ack_off,
                        input bit chg, input logic [1:0] new_ms);
    int n;
    int len;
    int end_c;
    n   = cyc;
    len = wait_len(int'(ms));
    check(req_ready == 1'b1, "R2 ready when idle", int'(req_ready), 1);
    expq.push_back('{n + 1, EV_SEND, kind});
    if (ack_off >= 1 && ack_off <= len) begin
      expq.push_back('{n + ack_off + 1, EV_DONE, 2'd0});
      end_c = n + ack_off + 1;
    end else begin
      expq.push_back('{n + len + 1, EV_TO, 2'd0});
      end_c = n + len + 1;
      if (ack_off == len + 1) begin
        expq.push_back('{n + len + 2, EV_LATE, 2'd0});
        end_c = n + len + 2;
      end
    end
    req_valid = 1'b1;
    req_kind  = kind;
    limit_ms  = ms;
    tick();
    req_valid = 1'b0;
    if (chg) limit_ms = new_ms;
    while (cyc <= end_c) begin
      ack_in = (cyc == n + ack_off);
      if (cyc == n + 2) check(req_ready == 1'b0, "R2 busy while waiting", int'(req_ready), 0);
      tick();
    end
    ack_in = 1'b0;
    limit_ms = ms;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // reset state
    check(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
    check({send_pulse, done_pulse, timeout_pulse, late_ack_pulse} == '0,
          "R12 quiet after reset", int'({send_pulse, done_pulse, timeout_pulse, late_ack_pulse}), 0);

    // R5 R1: acked early, each type
    do_req(2'd0, 2'd1, 2, 1'b0, 2'd0);
    do_req(2'd1, 2'd2, 5, 1'b0, 2'd0);
    // R4 R3: timeouts for each length
    do_req(2'd1, 2'd2, -1, 1'b0, 2'd0);
    do_req(2'd2, 2'd3, -1, 1'b0, 2'd0);
    // R10: repeated timeout with full wait
    do_req(2'd2, 2'd3, -1, 1'b0, 2'd0);
    // R5: ack one cycle before expiry
    do_req(2'd0, 2'd1, wait_len(1) - 1, 1'b0, 2'd0);
    // R6: ack on the expiry cycle
    do_req(2'd1, 2'd2, wait_len(2), 1'b0, 2'd0);
    // R7: ack right after timeout
    do_req(2'd2, 2'd1, wait_len(1) + 1, 1'b0, 2'd0);
    // R3: zero limit read as one
    do_req(2'd0, 2'd0, -1, 1'b0, 2'd0);
    // R9: limit changed mid-wait
    do_req(2'd1, 2'd1, -1, 1'b1, 2'd3);

    // R8: ack while idle, well away from any timeout
    repeat (3) tick();
    ack_in = 1'b1;
    tick();
    ack_in = 1'b0;
    check({done_pulse, timeout_pulse, late_ack_pulse} == '0, "R8 idle ack ignored",
          int'({done_pulse, timeout_pulse, late_ack_pulse}), 0);
    tick();
    check(req_ready == 1'b1, "R8 still idle", int'(req_ready), 1);

    // R11: reset during a wait
    n = cyc;
    expq.push_back('{n + 1, EV_SEND, 2'd2});
    req_valid = 1'b1;
    req_kind  = 2'd2;
    limit_ms  = 2'd3;
    tick();
    req_valid = 1'b0;
    repeat (3) tick();
    rst_n = 1'b0;
    expq.delete();
    repeat (2) tick();
    rst_n = 1'b1;
    check(req_ready == 1'b1, "R11 idle after mid-wait reset", int'(req_ready), 1);
    repeat (wait_len(3)) begin
      check(timeout_pulse == 1'b0, "R11 no stale timeout", int'(timeout_pulse), 0);
      tick();
    end
    do_req(2'd0, 2'd2, -1, 1'b0, 2'd0);

    repeat (3) tick();
    check(expq.size() == 0, "R4 all events seen", expq.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule